// File: doc/BRIEF.md
# I2C Master Arbitration Unit

This unit watches the serial data line while an I2C master on a shared bus sends an address byte and then data bytes. On each rising clock edge of a bit the master itself drives, it compares the level the master meant to put out with the level actually on the bus. A master that released the line (a one) but finds it pulled low has lost arbitration to another master. From then on it stops pulling the line for the rest of the transfer.

What follows a loss depends on where it happened. A loss inside a data byte ends the transfer at once with the "lost, not addressed" outcome. A loss inside the address byte does not end it right away. The unit keeps shifting in the winner's address and direction bit, then decides whether the winner is addressing this device. It may be addressed by its own address for writing or for reading, or by the general call for writing. The status code and the next operating mode follow from that decision. A START issued by this master clears the outcome and begins a new frame.

Top module: `i2c_arbiter`

## Requirements
- R1: After reset, arbLost is 0, statusValid is 0, statusCode is 0xF8, modeOut is 1 (not addressed) and sdaPullLow is 0.
- R2: One cycle after startGen, arbLost is 0, statusValid is 0, statusCode is 0xF8 and modeOut is 0 (master). The frame restarts at slot 0 of the address byte. Every byte takes 9 sclRise slots: slots 0 to 7 carry bits MSB first and slot 8 is the acknowledge.
- R3: On an sclRise in slots 0 to 7 with txBit 1 and sdaIn 0, arbLost is 1 from the next cycle on. Equal bits, and txBit 0, never set it.
- R4: The acknowledge slot (slot 8) is never compared: sdaIn 0 there with txBit 1 leaves arbLost unchanged.
- R5: sdaPullLow is 1 only in slots 0 to 7 of a started frame, while arbLost is 0 and txBit is 0.
- R6: A loss in a data byte gives statusCode 0x38, statusValid 1 and modeOut 1 on the same cycle as arbLost.
- R7: After a loss in the address byte, the seven address bits are slots 0 to 6 and the direction is slot 7 (1 = read). If the address seen on the bus equals ownAddr with direction write, the result is statusCode 0x68 and modeOut 2 (slave receive). It is given one cycle after the slot 7 sclRise.
- R8: Address 0 with direction write gives 0x78 with modeOut 2 when gcEnable is 1. It gives 0x38 with modeOut 1 when gcEnable is 0.
- R9: Own address with direction read gives statusCode 0xB0 and modeOut 3 (slave transmit).
- R10: After a loss in the address byte, any other address gives 0x38 with modeOut 1.
- R11: A loss on the direction bit itself is decided on that same sclRise.
- R12: Once set, arbLost and the status outcome stay unchanged until the next startGen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startGen | input | 1 | Pulse: this master issued a START |
| sclRise | input | 1 | Pulse: SCL rising edge, bus level valid |
| sdaIn | input | 1 | Sampled SDA level |
| txBit | input | 1 | Bit this master sends in the current slot |
| ownAddr | input | ADDR_W | This device's slave address |
| gcEnable | input | 1 | Respond to the general call address |
| sdaPullLow | output | 1 | Master pulls SDA low |
| arbLost | output | 1 | Arbitration lost in this frame |
| statusValid | output | 1 | statusCode holds an arbitration outcome |
| statusCode | output | 8 | Outcome code, 0xF8 when none |
| modeOut | output | 2 | 0 master, 1 not addressed, 2 slave receive, 3 slave transmit |

## Verification
The hardest case to reach is a loss early in the address byte followed by a winner address that matches, exactly or as the general call. The bus must stay low on the master's first one bit and then carry the winner's bits through slot 7. The stimulus models the bus as the wired AND of both masters until the loss, and as the winner alone after it. It sweeps every winner byte against an all-ones master byte, with the general call enabled and disabled. Further sweeps vary the master byte against winners built from the own address, and vary the data byte after an address byte both masters share.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  typedef enum logic [1:0] {
    MODE_MASTER = 2'd0,
    MODE_UNADDR = 2'd1,
    MODE_SLV_RX = 2'd2,
    MODE_SLV_TX = 2'd3
  } arbMode_t;

  typedef struct packed {
    logic clrFrame;
    logic stepBit;
  } dpStrobes_t;

  localparam logic [7:0] ST_NONE     = 8'hF8;
  localparam logic [7:0] ST_LOST     = 8'h38;
  localparam logic [7:0] ST_LOST_SRX = 8'h68;
  localparam logic [7:0] ST_LOST_GC  = 8'h78;
  localparam logic [7:0] ST_LOST_STX = 8'hB0;
endpackage

// File: rtl/i2c_arb_datapath.sv
module i2c_arb_datapath
  import i2c_arb_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              gcEnable,
  output logic              masterSlot,
  output logic              addrPhase,
  output logic              lastAddrBit,
  output logic              ownHit,
  output logic              gcHit
);
  localparam int RW_POS  = ADDR_W;
  localparam int ACK_POS = ADDR_W + 1;
  localparam int IDX_W   = $clog2(ACK_POS + 1);

  logic [IDX_W-1:0]  bitIdx;
  logic              inAddr;
  logic              active;
  logic [ADDR_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx   <= '0;
      inAddr   <= 1'b0;
      active   <= 1'b0;
      shiftReg <= '0;
    end else if (strobes.clrFrame) begin
      bitIdx   <= '0;
      inAddr   <= 1'b1;
      active   <= 1'b1;
      shiftReg <= '0;
    end else if (strobes.stepBit && active) begin
      shiftReg <= {shiftReg[ADDR_W-2:0], sdaIn};
      if (bitIdx == IDX_W'(ACK_POS)) begin
        bitIdx <= '0;
        inAddr <= 1'b0;
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  always_comb begin
    masterSlot  = active && (bitIdx != IDX_W'(ACK_POS));
    addrPhase   = active && inAddr;
    lastAddrBit = addrPhase && (bitIdx == IDX_W'(RW_POS));
    ownHit      = (shiftReg == ownAddr);
    gcHit       = gcEnable && (shiftReg == '0);
  end
endmodule

// File: rtl/i2c_arb_control.sv
module i2c_arb_control
  import i2c_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startGen,
  input  logic       sclRise,
  input  logic       sdaIn,
  input  logic       txBit,
  input  logic       masterSlot,
  input  logic       addrPhase,
  input  logic       lastAddrBit,
  input  logic       ownHit,
  input  logic       gcHit,
  output dpStrobes_t strobes,
  output logic       arbLost,
  output logic       statusValid,
  output logic [7:0] statusCode,
  output arbMode_t   modeOut
);
  logic mismatch;
  logic decideAddr;
  logic stepNow;

  always_comb begin
    strobes.clrFrame = startGen;
    strobes.stepBit  = sclRise && !startGen;
    stepNow          = sclRise && !startGen;
    mismatch         = stepNow && masterSlot && !arbLost && txBit && !sdaIn;
    decideAddr       = stepNow && lastAddrBit && (arbLost || mismatch) && !statusValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      arbLost     <= 1'b0;
      statusValid <= 1'b0;
      statusCode  <= ST_NONE;
      modeOut     <= MODE_UNADDR;
    end else if (startGen) begin
      arbLost     <= 1'b0;
      statusValid <= 1'b0;
      statusCode  <= ST_NONE;
      modeOut     <= MODE_MASTER;
    end else begin
      if (mismatch) begin
        arbLost <= 1'b1;
        if (!addrPhase) begin
          statusValid <= 1'b1;
          statusCode  <= ST_LOST;
          modeOut     <= MODE_UNADDR;
        end
      end
      if (decideAddr) begin
        statusValid <= 1'b1;
        if (ownHit) begin
          statusCode <= sdaIn ? ST_LOST_STX : ST_LOST_SRX;
          modeOut    <= sdaIn ? MODE_SLV_TX : MODE_SLV_RX;
        end else if (gcHit && !sdaIn) begin
          statusCode <= ST_LOST_GC;
          modeOut    <= MODE_SLV_RX;
        end else begin
          statusCode <= ST_LOST;
          modeOut    <= MODE_UNADDR;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_arbiter.sv
module i2c_arbiter
  import i2c_arb_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startGen,
  input  logic              sclRise,
  input  logic              sdaIn,
  input  logic              txBit,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              gcEnable,
  output logic              sdaPullLow,
  output logic              arbLost,
  output logic              statusValid,
  output logic [7:0]        statusCode,
  output logic [1:0]        modeOut
);
  dpStrobes_t strobes;
  logic       masterSlot;
  logic       addrPhase;
  logic       lastAddrBit;
  logic       ownHit;
  logic       gcHit;
  arbMode_t   modeInt;

  i2c_arb_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sdaIn(sdaIn),
    .ownAddr(ownAddr), .gcEnable(gcEnable), .masterSlot(masterSlot),
    .addrPhase(addrPhase), .lastAddrBit(lastAddrBit),
    .ownHit(ownHit), .gcHit(gcHit)
  );

  i2c_arb_control u_ctl (
    .clk(clk), .rstN(rstN), .startGen(startGen), .sclRise(sclRise),
    .sdaIn(sdaIn), .txBit(txBit), .masterSlot(masterSlot),
    .addrPhase(addrPhase), .lastAddrBit(lastAddrBit), .ownHit(ownHit),
    .gcHit(gcHit), .strobes(strobes), .arbLost(arbLost),
    .statusValid(statusValid), .statusCode(statusCode), .modeOut(modeInt)
  );

  assign modeOut    = modeInt;
  assign sdaPullLow = masterSlot && !arbLost && !txBit;
endmodule

// File: rtl/i2c_arbiter_checker.sv
module i2c_arbiter_checker (
  input logic       clk,
  input logic       rstN,
  input logic       startGen,
  input logic       sclRise,
  input logic       sdaIn,
  input logic       txBit,
  input logic       sdaPullLow,
  input logic       arbLost,
  input logic       statusValid,
  input logic [7:0] statusCode,
  input logic [1:0] modeOut
);
  assert_release_after_loss_R5: assert property (@(posedge clk) disable iff (!rstN)
    arbLost |-> !sdaPullLow);

  assert_lost_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    (arbLost && !startGen) |=> arbLost);

  assert_status_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && !startGen) |=> (statusValid && $stable(statusCode) && $stable(modeOut)));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    startGen |=> (!arbLost && !statusValid && statusCode == 8'hF8 && modeOut == 2'd0));

  assert_loss_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arbLost) |-> ($past(sclRise) && $past(txBit) && !$past(sdaIn)));

  assert_outcome_needs_loss_R6: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |-> arbLost);

  assert_read_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && statusCode == 8'hB0) |-> modeOut == 2'd3);
endmodule

bind i2c_arbiter i2c_arbiter_checker u_chk (
  .clk(clk), .rstN(rstN), .startGen(startGen), .sclRise(sclRise),
  .sdaIn(sdaIn), .txBit(txBit), .sdaPullLow(sdaPullLow), .arbLost(arbLost),
  .statusValid(statusValid), .statusCode(statusCode), .modeOut(modeOut)
);

// File: tb/i2c_arbiter_tb.sv
`timescale 1ns/1ps
module i2c_arbiter_tb;
  localparam logic [6:0] OWN = 7'h35;

  logic       clk = 1'b0;
  logic       rstN, startGen, sclRise, sdaIn, txBit, gcEnable;
  logic [6:0] ownAddr;
  logic       sdaPullLow, arbLost, statusValid;
  logic [7:0] statusCode;
  logic [1:0] modeOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  i2c_arbiter u_dut (
    .clk(clk), .rstN(rstN), .startGen(startGen), .sclRise(sclRise),
    .sdaIn(sdaIn), .txBit(txBit), .ownAddr(ownAddr), .gcEnable(gcEnable),
    .sdaPullLow(sdaPullLow), .arbLost(arbLost), .statusValid(statusValid),
    .statusCode(statusCode), .modeOut(modeOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic doFrame(input logic [7:0] m0, input logic [7:0] w0,
                         input logic [7:0] m1, input logic [7:0] w1, input logic gc);
    logic       eLost, eValid, rw, mb, wb, bus, own, gcm;
    logic [7:0] eCode;
    logic [1:0] eMode;
    logic [6:0] busAddr;
    string      tag;
    eLost = 0; eValid = 0; eCode = 8'hF8; eMode = 2'd0; busAddr = '0; tag = "R10";
    gcEnable = gc;
    @(negedge clk) startGen = 1'b1;
    @(negedge clk) startGen = 1'b0;
    chk("R2 code", statusCode, 8'hF8);
    chk("R2 lost", arbLost, 0);
    chk("R2 mode", modeOut, 0);
    for (int b = 0; b < 2; b++) begin
      for (int s = 0; s < 9; s++) begin
        mb  = (s < 8) ? ((b == 0) ? m0[7-s] : m1[7-s]) : 1'b1;
        wb  = (s < 8) ? ((b == 0) ? w0[7-s] : w1[7-s]) : 1'b0;
        bus = (s == 8) ? 1'b0 : (eLost ? wb : (mb & wb));
        txBit = mb; sdaIn = bus; sclRise = 1'b1;
        #1;
        chk("R5 pull", sdaPullLow, (s < 8) && !eLost && !mb);
        @(negedge clk) sclRise = 1'b0;
        if (s < 8) begin
          if (b == 0 && s < 7) busAddr = {busAddr[5:0], bus};
          if (!eLost && mb && !bus) begin
            eLost = 1;
            if (b == 1) begin
              eValid = 1; eCode = 8'h38; eMode = 2'd1; tag = "R6";
            end else if (s == 7) begin
              tag = "R11";
            end
          end
          if (b == 0 && s == 7 && eLost) begin
            rw  = bus;
            own = (busAddr == OWN);
            gcm = (busAddr == 7'd0) && gc;
            eValid = 1;
            if (own) begin
              eCode = rw ? 8'hB0 : 8'h68; eMode = rw ? 2'd3 : 2'd2;
              if (tag != "R11") tag = rw ? "R9" : "R7";
            end else if (gcm && !rw) begin
              eCode = 8'h78; eMode = 2'd2;
              if (tag != "R11") tag = "R8";
            end else begin
              eCode = 8'h38; eMode = 2'd1;
              if (tag != "R11") tag = (busAddr == 7'd0) ? "R8" : "R10";
            end
          end
          chk(eLost ? "R12 lost" : "R3 lost", arbLost, eLost);
        end else begin
          chk("R4 ack", arbLost, eLost);
        end
      end
    end
    if (!eLost) tag = "R3";
    chk({tag, " code"}, statusCode, eCode);
    chk({tag, " valid"}, statusValid, eValid);
    chk({tag, " mode"}, modeOut, eMode);
  endtask

  initial begin
    rstN = 0; startGen = 0; sclRise = 0; sdaIn = 1; txBit = 1;
    gcEnable = 0; ownAddr = OWN;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 lost", arbLost, 0);
    chk("R1 valid", statusValid, 0);
    chk("R1 code", statusCode, 8'hF8);
    chk("R1 mode", modeOut, 1);
    chk("R1 pull", sdaPullLow, 0);
    // Address-phase loss: every winner byte against an all-ones master byte
    for (int g = 0; g < 2; g++)
      for (int w = 0; w < 256; w++)
        doFrame(8'hFF, 8'(w), 8'hA5, 8'(w) ^ 8'h5A, 1'(g));
    // Data-phase loss: shared address byte, every winner data byte
    for (int w = 0; w < 256; w++)
      doFrame(8'h42, 8'h42, 8'hC3, 8'(w), 1'b1);
    // Varied master bytes against winners built from own address / general call
    for (int m = 0; m < 256; m++) begin
      case (m % 4)
        0: doFrame(8'(m), {OWN, 1'b0}, 8'h00, 8'hFF, 1'b1);
        1: doFrame(8'(m), {OWN, 1'b1}, 8'h00, 8'hFF, 1'b0);
        2: doFrame(8'(m), 8'h00, 8'h00, 8'hFF, 1'b1);
        default: doFrame(8'(m), 8'h00, 8'h00, 8'hFF, 1'b0);
      endcase
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule